// File: doc/BRIEF.md
# Multithreaded Fetch Status Controller

This block holds one status register per hardware thread of an instruction fetch stage. Each cycle it takes four kinds of input. The first is the block and unblock pulses from four downstream pipeline stages. The second is redirect (squash) requests from the commit and decode stages. The third is the handshakes of a single shared instruction-cache miss port: issue, refusal, retry and response. The last is the fault and quiesce events raised by the fetch datapath. From these it computes each thread's next status, the program counter to fetch from after a redirect, and one active/inactive flag for the whole stage.

The per-thread decision follows a fixed priority, highest first:
1. commit squash
2. a reorder buffer that is still squashing
3. decode squash
4. stall
5. return from Blocked or Squashing

Only when none of these applies does the thread act on cache and datapath events. Cache responses are accepted only for the request a thread is still waiting on. A per-thread tag identifies that request. Stale or unmatched responses are counted and discarded. At most one thread may own the cache port while it waits for a retry. Any redirect of that owner frees the port.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread reads Running (code 0), all stall bits are clear, the cache port is not blocked, the dropped-response count is 0, every miss tag is 0, `fetch_pc` is 0, `fetch_npc` is INST_BYTES, and `stage_active`, `stage_woke` and `stage_slept` are 0.
- R2: Each thread has a sticky stall bit per downstream stage, at bit `thread*NSTG+stage` of `stg_block`/`stg_unblock`. A block pulse sets the bit and an unblock pulse clears it; the two are never high on the same bit together. If any updated bit of the thread, or `ctx_stall`, is set and the thread is not in WaitResponse (4) or WaitRetry (5), the thread becomes Blocked (3). A Blocked or Squashing (2) thread with no stall and no squash becomes Running.
- R3: A commit squash overrides every other input of the thread. The thread becomes Squashing, `fetch_pc` takes the commit target and `fetch_npc` the target plus INST_BYTES.
- R4: While the reorder buffer reports squashing, the thread becomes or stays Squashing with no redirect. A decode squash redirects, as in R3 but with the decode target, only when the thread is not currently Squashing; otherwise the squash is ignored and the PCs are kept.
- R5: A miss request on the shared port is taken only for a thread in Running that no higher-priority input overrides, and only while the port is not blocked. The thread's miss tag becomes its count of taken requests modulo 2^TAG_W. If the request is accepted the thread goes to WaitResponse (4). If it is refused the thread goes to WaitRetry (5) and `cache_blocked` is set.
- R6: A response is taken only when its thread is in WaitResponse, its tag equals that thread's miss tag, and no higher-priority input overrides the thread that cycle. The thread then goes to Blocked if stalled, else to AccessComplete (6), which becomes Running on the next cycle. Every other response increments `dropped_resp`.
- R7: A retry pulse with acceptance moves the owning thread from WaitRetry to WaitResponse and clears `cache_blocked`. A refused retry changes nothing. Any squash of the owning thread clears `cache_blocked`.
- R8: A Running thread with no override and no taken miss request goes to TrapPending (7) on a fault, otherwise to QuiescePending (8) on a quiesce event. It leaves those states only through a squash or a stall.
- R9: `stage_active` is 1 in the cycle after the statuses are updated exactly when some thread with `thread_active` set has reached Running, Squashing or AccessComplete. `stage_woke` and `stage_slept` pulse for one cycle, together with the matching change of `stage_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_block | input | NT*NSTG | Per thread, per stage block pulses |
| stg_unblock | input | NT*NSTG | Per thread, per stage unblock pulses |
| ctx_stall | input | 1 | Global stall applied to all threads |
| thread_active | input | NT | Threads counted for the stage-active flag |
| cmt_squash | input | NT | Commit redirect request |
| cmt_rob_busy | input | NT | Reorder buffer still squashing |
| cmt_target | input | NT*PC_W | Commit redirect targets |
| dec_squash | input | NT | Decode redirect request |
| dec_target | input | NT*PC_W | Decode redirect targets |
| miss_valid | input | 1 | Miss request offered on the shared port |
| miss_tid | input | TID_W | Thread of the offered miss |
| miss_accept | input | 1 | Cache accepts the offered miss |
| retry_pulse | input | 1 | Cache signals a retry opportunity |
| retry_accept | input | 1 | Retried request accepted |
| resp_valid | input | 1 | Cache response present |
| resp_tid | input | TID_W | Thread of the response |
| resp_tag | input | TAG_W | Tag carried by the response |
| fault_evt | input | NT | Fetch fault per thread |
| quiesce_evt | input | NT | Quiesce instruction per thread |
| thread_state | output | NT*4 | Status code per thread |
| fetch_pc | output | NT*PC_W | Current fetch PC per thread |
| fetch_npc | output | NT*PC_W | Following PC per thread |
| miss_tag | output | NT*TAG_W | Tag of each thread's latest miss |
| cache_blocked | output | 1 | Shared port waiting for a retry |
| dropped_resp | output | CNT_W | Count of discarded responses |
| stage_active | output | 1 | Stage has work |
| stage_woke | output | 1 | One-cycle pulse on becoming active |
| stage_slept | output | 1 | One-cycle pulse on becoming inactive |

## Verification
The hardest situation to reach is a response or a retry that arrives in the same cycle as a squash, stall or reorder-buffer hold on the thread it belongs to. The thread must already be waiting on a miss with a known tag, and at the same time the port must be blocked by the other thread's refused request. The directed part first builds that layout: one thread waiting for a response and one holding the port in WaitRetry. The seeded random phase then overlaps responses, mostly with correct tags, with frequent stall and squash pulses for thousands of cycles, so that filtered responses and released ports occur many times.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    TS_RUN     = 4'd0,
    TS_IDLE    = 4'd1,
    TS_SQUASH  = 4'd2,
    TS_BLOCK   = 4'd3,
    TS_WRESP   = 4'd4,
    TS_WRETRY  = 4'd5,
    TS_ACOMP   = 4'd6,
    TS_TRAP    = 4'd7,
    TS_QUIESCE = 4'd8
  } tstate_e;

  // Status codes that keep the stage awake.
  function automatic logic st_busy(tstate_e s);
    return (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_ACOMP);
  endfunction

  // Status codes in which a stall does not force Blocked.
  function automatic logic st_cache_wait(tstate_e s);
    return (s == TS_WRESP) || (s == TS_WRETRY);
  endfunction

endpackage

// File: rtl/fsc_stall_bits.sv
module fsc_stall_bits #(
  parameter int NSTG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] blk_i,
  input  logic [NSTG-1:0] unblk_i,
  input  logic            ctx_stall_i,
  output logic            stalled_o
);

  logic [NSTG-1:0] bits_q;
  logic [NSTG-1:0] bits_nx;

  // Set wins over clear; both together is an illegal input.
  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_bit
      assign bits_nx[s] = blk_i[s] ? 1'b1 : (unblk_i[s] ? 1'b0 : bits_q[s]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_nx;
  end

  // Decisions in this cycle use the freshly updated bits.
  assign stalled_o = (|bits_nx) | ctx_stall_i;

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmt_sq_i,
  input  logic            rob_busy_i,
  input  logic            dec_sq_i,
  input  logic [PC_W-1:0] cmt_pc_i,
  input  logic [PC_W-1:0] dec_pc_i,
  input  logic            stalled_i,
  input  logic            issue_acc_i,
  input  logic            issue_ref_i,
  input  logic            resp_take_i,
  input  logic            retry_take_i,
  input  logic            fault_i,
  input  logic            quiesce_i,
  output tstate_e         state_q,
  output tstate_e         state_nx,
  output logic            quiet_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] npc_q
);

  logic [PC_W-1:0] tgt;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] a);
    return a + PC_W'(INST_BYTES);
  endfunction

  // Fixed priority: commit, ROB hold, decode, stall, release, then events.
  always_comb begin
    state_nx   = state_q;
    quiet_o    = 1'b0;
    redirect_o = 1'b0;
    tgt        = cmt_pc_i;
    if (cmt_sq_i) begin
      state_nx   = TS_SQUASH;
      redirect_o = 1'b1;
    end else if (rob_busy_i) begin
      state_nx = TS_SQUASH;
    end else if (dec_sq_i && state_q != TS_SQUASH) begin
      state_nx   = TS_SQUASH;
      redirect_o = 1'b1;
      tgt        = dec_pc_i;
    end else if (stalled_i && !st_cache_wait(state_q)) begin
      state_nx = TS_BLOCK;
    end else if (state_q == TS_BLOCK || state_q == TS_SQUASH) begin
      state_nx = TS_RUN;
    end else begin
      quiet_o = 1'b1;
      case (state_q)
        TS_WRESP:  if (resp_take_i) state_nx = stalled_i ? TS_BLOCK : TS_ACOMP;
        TS_ACOMP:  state_nx = TS_RUN;
        TS_RUN: begin
          if (issue_acc_i)      state_nx = TS_WRESP;
          else if (issue_ref_i) state_nx = TS_WRETRY;
          else if (fault_i)     state_nx = TS_TRAP;
          else if (quiesce_i)   state_nx = TS_QUIESCE;
        end
        TS_WRETRY: if (retry_take_i) state_nx = TS_WRESP;
        default:   state_nx = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TS_RUN;
      pc_q    <= '0;
      npc_q   <= step_pc('0);
    end else begin
      state_q <= state_nx;
      if (redirect_o) begin
        pc_q  <= tgt;
        npc_q <= step_pc(tgt);
      end
    end
  end

endmodule

// File: rtl/fsc_miss_tracker.sv
module fsc_miss_tracker
  import fsc_pkg::*;
#(
  parameter int NT    = 2,
  parameter int TID_W = 1,
  parameter int TAG_W = 3,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state_i [NT],
  input  logic [NT-1:0]     quiet_i,
  input  logic              miss_valid_i,
  input  logic [TID_W-1:0]  miss_tid_i,
  input  logic              miss_accept_i,
  input  logic              retry_pulse_i,
  input  logic              retry_accept_i,
  input  logic              resp_valid_i,
  input  logic [TID_W-1:0]  resp_tid_i,
  input  logic [TAG_W-1:0]  resp_tag_i,
  output logic [NT-1:0]     issue_acc_o,
  output logic [NT-1:0]     issue_ref_o,
  output logic [NT-1:0]     resp_take_o,
  output logic [NT-1:0]     retry_take_o,
  output logic [NT*TAG_W-1:0] tag_o,
  output logic              cblk_o,
  output logic [CNT_W-1:0]  drop_cnt_o,
  output logic              resp_drop_o,
  output logic              release_o
);

  logic [TAG_W-1:0] seq_q [NT];
  logic [TAG_W-1:0] tag_q [NT];
  logic [NT-1:0]    issue_hit;
  logic [TID_W-1:0] owner_q;
  logic             cblk_q;
  logic             owner_quiet;
  logic [CNT_W-1:0] drop_q;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      assign issue_hit[t] = miss_valid_i && !cblk_q && (miss_tid_i == TID_W'(t))
                            && (state_i[t] == TS_RUN) && quiet_i[t];
      assign issue_acc_o[t] = issue_hit[t] && miss_accept_i;
      assign issue_ref_o[t] = issue_hit[t] && !miss_accept_i;
      assign resp_take_o[t] = resp_valid_i && (resp_tid_i == TID_W'(t))
                              && (state_i[t] == TS_WRESP) && quiet_i[t]
                              && (resp_tag_i == tag_q[t]);
      assign retry_take_o[t] = cblk_q && (owner_q == TID_W'(t)) && quiet_i[t]
                               && (state_i[t] == TS_WRETRY)
                               && retry_pulse_i && retry_accept_i;
      assign tag_o[t*TAG_W +: TAG_W] = tag_q[t];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          seq_q[t] <= '0;
          tag_q[t] <= '0;
        end else if (issue_hit[t]) begin
          tag_q[t] <= seq_q[t];
          seq_q[t] <= seq_q[t] + TAG_W'(1);
        end
      end
    end
  endgenerate

  always_comb begin
    owner_quiet = 1'b0;
    for (int t = 0; t < NT; t++)
      if (owner_q == TID_W'(t)) owner_quiet = quiet_i[t];
  end

  // A squash of the owner gives the port back.
  assign release_o   = cblk_q && !owner_quiet;
  assign resp_drop_o = resp_valid_i && !(|resp_take_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cblk_q  <= 1'b0;
      owner_q <= '0;
      drop_q  <= '0;
    end else begin
      if (|issue_ref_o) begin
        cblk_q  <= 1'b1;
        owner_q <= miss_tid_i;
      end else if (release_o || (|retry_take_o)) begin
        cblk_q <= 1'b0;
      end
      if (resp_drop_o) drop_q <= drop_q + CNT_W'(1);
    end
  end

  assign cblk_o     = cblk_q;
  assign drop_cnt_o = drop_q;

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NT         = 2,
  parameter int NSTG       = 4,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int TAG_W      = 3,
  parameter int CNT_W      = 8,
  parameter int TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NT*NSTG-1:0]       stg_block,
  input  logic [NT*NSTG-1:0]       stg_unblock,
  input  logic                     ctx_stall,
  input  logic [NT-1:0]            thread_active,
  input  logic [NT-1:0]            cmt_squash,
  input  logic [NT-1:0]            cmt_rob_busy,
  input  logic [NT*PC_W-1:0]       cmt_target,
  input  logic [NT-1:0]            dec_squash,
  input  logic [NT*PC_W-1:0]       dec_target,
  input  logic                     miss_valid,
  input  logic [TID_W-1:0]         miss_tid,
  input  logic                     miss_accept,
  input  logic                     retry_pulse,
  input  logic                     retry_accept,
  input  logic                     resp_valid,
  input  logic [TID_W-1:0]         resp_tid,
  input  logic [TAG_W-1:0]         resp_tag,
  input  logic [NT-1:0]            fault_evt,
  input  logic [NT-1:0]            quiesce_evt,
  output logic [NT*STATE_W-1:0]    thread_state,
  output logic [NT*PC_W-1:0]       fetch_pc,
  output logic [NT*PC_W-1:0]       fetch_npc,
  output logic [NT*TAG_W-1:0]      miss_tag,
  output logic                     cache_blocked,
  output logic [CNT_W-1:0]         dropped_resp,
  output logic                     stage_active,
  output logic                     stage_woke,
  output logic                     stage_slept
);

  tstate_e       st_q  [NT];
  tstate_e       st_nx [NT];
  logic [NT-1:0] stalled;
  logic [NT-1:0] quiet;
  logic [NT-1:0] redirect;
  logic [NT-1:0] issue_acc;
  logic [NT-1:0] issue_ref;
  logic [NT-1:0] resp_take;
  logic [NT-1:0] retry_take;
  logic          resp_drop;
  logic          port_release;
  logic          act_nx;
  logic          active_q, woke_q, slept_q;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thread
      fsc_stall_bits #(.NSTG(NSTG)) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_i       (stg_block[t*NSTG +: NSTG]),
        .unblk_i     (stg_unblock[t*NSTG +: NSTG]),
        .ctx_stall_i (ctx_stall),
        .stalled_o   (stalled[t])
      );

      fsc_thread_fsm #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmt_sq_i     (cmt_squash[t]),
        .rob_busy_i   (cmt_rob_busy[t]),
        .dec_sq_i     (dec_squash[t]),
        .cmt_pc_i     (cmt_target[t*PC_W +: PC_W]),
        .dec_pc_i     (dec_target[t*PC_W +: PC_W]),
        .stalled_i    (stalled[t]),
        .issue_acc_i  (issue_acc[t]),
        .issue_ref_i  (issue_ref[t]),
        .resp_take_i  (resp_take[t]),
        .retry_take_i (retry_take[t]),
        .fault_i      (fault_evt[t]),
        .quiesce_i    (quiesce_evt[t]),
        .state_q      (st_q[t]),
        .state_nx     (st_nx[t]),
        .quiet_o      (quiet[t]),
        .redirect_o   (redirect[t]),
        .pc_q         (fetch_pc[t*PC_W +: PC_W]),
        .npc_q        (fetch_npc[t*PC_W +: PC_W])
      );

      assign thread_state[t*STATE_W +: STATE_W] = st_q[t];
    end
  endgenerate

  fsc_miss_tracker #(
    .NT(NT), .TID_W(TID_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_miss (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_i        (st_q),
    .quiet_i        (quiet),
    .miss_valid_i   (miss_valid),
    .miss_tid_i     (miss_tid),
    .miss_accept_i  (miss_accept),
    .retry_pulse_i  (retry_pulse),
    .retry_accept_i (retry_accept),
    .resp_valid_i   (resp_valid),
    .resp_tid_i     (resp_tid),
    .resp_tag_i     (resp_tag),
    .issue_acc_o    (issue_acc),
    .issue_ref_o    (issue_ref),
    .resp_take_o    (resp_take),
    .retry_take_o   (retry_take),
    .tag_o          (miss_tag),
    .cblk_o         (cache_blocked),
    .drop_cnt_o     (dropped_resp),
    .resp_drop_o    (resp_drop),
    .release_o      (port_release)
  );

  always_comb begin
    act_nx = 1'b0;
    for (int t = 0; t < NT; t++)
      if (thread_active[t] && st_busy(st_nx[t])) act_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      woke_q   <= 1'b0;
      slept_q  <= 1'b0;
    end else begin
      active_q <= act_nx;
      woke_q   <= act_nx && !active_q;
      slept_q  <= !act_nx && active_q;
    end
  end

  assign stage_active = active_q;
  assign stage_woke   = woke_q;
  assign stage_slept  = slept_q;

endmodule

// File: rtl/fetch_status_ctrl_chk.sv
module fetch_status_ctrl_chk #(
  parameter int NT         = 2,
  parameter int NSTG       = 4,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NT*NSTG-1:0]  stg_block,
  input logic [NT*NSTG-1:0]  stg_unblock,
  input logic [NT-1:0]       cmt_squash,
  input logic [NT-1:0]       cmt_rob_busy,
  input logic [NT*PC_W-1:0]  cmt_target,
  input logic [NT*4-1:0]     thread_state,
  input logic [NT*PC_W-1:0]  fetch_pc,
  input logic [NT*PC_W-1:0]  fetch_npc,
  input logic                cache_blocked,
  input logic [CNT_W-1:0]    dropped_resp,
  input logic                resp_drop,
  input logic                port_release,
  input logic                stage_active,
  input logic                stage_woke,
  input logic                stage_slept
);

  logic any_retry_wait;
  always_comb begin
    any_retry_wait = 1'b0;
    for (int t = 0; t < NT; t++)
      if (thread_state[t*4 +: 4] == 4'd5) any_retry_wait = 1'b1;
  end

  // R2: block and unblock never share a bit
  a_r2_no_block_unblock: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_block & stg_unblock) == '0);

  generate
    for (genvar t = 0; t < NT; t++) begin : g_chk
      // R3: commit squash redirects the thread
      a_r3_commit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash[t] |=> (thread_state[t*4 +: 4] == 4'd2)
          && (fetch_pc[t*PC_W +: PC_W] == $past(cmt_target[t*PC_W +: PC_W]))
          && (fetch_npc[t*PC_W +: PC_W] ==
              $past(cmt_target[t*PC_W +: PC_W]) + PC_W'(INST_BYTES)));

      // R4: reorder-buffer hold keeps the thread squashing
      a_r4_rob_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_rob_busy[t] |=> thread_state[t*4 +: 4] == 4'd2);
    end
  endgenerate

  // R6: every discarded response is counted
  a_r6_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    resp_drop |=> dropped_resp == $past(dropped_resp) + CNT_W'(1));

  // R7: a blocked port always has a thread waiting to retry
  a_r7_owner_waits: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> any_retry_wait);

  // R7: releasing the port clears the blocked flag
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    port_release |=> !cache_blocked);

  // R9: wake and sleep pulses agree with the active flag
  a_r9_woke_active: assert property (@(posedge clk) disable iff (!rst_n)
    stage_woke |-> stage_active && !$past(stage_active));
  a_r9_slept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stage_slept |-> !stage_active && $past(stage_active));

endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(
  .NT(NT), .NSTG(NSTG), .PC_W(PC_W), .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stg_block     (stg_block),
  .stg_unblock   (stg_unblock),
  .cmt_squash    (cmt_squash),
  .cmt_rob_busy  (cmt_rob_busy),
  .cmt_target    (cmt_target),
  .thread_state  (thread_state),
  .fetch_pc      (fetch_pc),
  .fetch_npc     (fetch_npc),
  .cache_blocked (cache_blocked),
  .dropped_resp  (dropped_resp),
  .resp_drop     (resp_drop),
  .port_release  (port_release),
  .stage_active  (stage_active),
  .stage_woke    (stage_woke),
  .stage_slept   (stage_slept)
);

// File: tb/fetch_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_status_ctrl_tb_top;

  localparam int NT = 2, NSTG = 4, PC_W = 32, INST_BYTES = 4;
  localparam int TAG_W = 3, CNT_W = 8, TID_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NT*NSTG-1:0] stg_block, stg_unblock;
  logic ctx_stall;
  logic [NT-1:0] thread_active, cmt_squash, cmt_rob_busy, dec_squash, fault_evt, quiesce_evt;
  logic [NT*PC_W-1:0] cmt_target, dec_target;
  logic miss_valid, miss_accept, retry_pulse, retry_accept, resp_valid;
  logic [TID_W-1:0] miss_tid, resp_tid;
  logic [TAG_W-1:0] resp_tag;
  logic [NT*4-1:0] thread_state;
  logic [NT*PC_W-1:0] fetch_pc, fetch_npc;
  logic [NT*TAG_W-1:0] miss_tag;
  logic cache_blocked, stage_active, stage_woke, stage_slept;
  logic [CNT_W-1:0] dropped_resp;

  fetch_status_ctrl dut_i (.*);

  // reference state
  int m_st [NT];
  bit m_stl [NT][NSTG];
  logic [PC_W-1:0] m_pc [NT];
  logic [PC_W-1:0] m_npc [NT];
  logic [TAG_W-1:0] m_seq [NT];
  logic [TAG_W-1:0] m_tag [NT];
  bit m_cblk, m_act, m_on, m_off;
  int m_own;
  logic [CNT_W-1:0] m_drop;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string lbl = "R1";

  task automatic clear_in();
    stg_block = '0; stg_unblock = '0; ctx_stall = 0;
    cmt_squash = '0; cmt_rob_busy = '0; dec_squash = '0;
    cmt_target = '0; dec_target = '0;
    miss_valid = 0; miss_tid = '0; miss_accept = 0;
    retry_pulse = 0; retry_accept = 0;
    resp_valid = 0; resp_tid = '0; resp_tag = '0;
    fault_evt = '0; quiesce_evt = '0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_st[t] = 0; m_pc[t] = '0; m_npc[t] = PC_W'(INST_BYTES);
      m_seq[t] = '0; m_tag[t] = '0;
      for (int s = 0; s < NSTG; s++) m_stl[t][s] = 0;
    end
    m_cblk = 0; m_own = 0; m_drop = '0; m_act = 0; m_on = 0; m_off = 0;
  endtask

  function automatic bit busy_code(int c);
    return c == 0 || c == 2 || c == 6;
  endfunction

  // Next state from the requirements, applied at the coming clock edge.
  task automatic model_step();
    int n [NT]; bit q [NT]; bit stl [NT]; bit rd [NT];
    logic [PC_W-1:0] rpc [NT];
    int iss; bit took; bit ncblk; bit nact;
    iss = -1; took = 0; ncblk = m_cblk;
    for (int t = 0; t < NT; t++) begin
      stl[t] = ctx_stall;
      for (int s = 0; s < NSTG; s++) begin
        if (stg_block[t*NSTG+s]) m_stl[t][s] = 1;
        else if (stg_unblock[t*NSTG+s]) m_stl[t][s] = 0;
        stl[t] |= m_stl[t][s];
      end
      n[t] = m_st[t]; q[t] = 0; rd[t] = 0; rpc[t] = '0;
      if (cmt_squash[t]) begin n[t] = 2; rd[t] = 1; rpc[t] = cmt_target[t*PC_W +: PC_W]; end
      else if (cmt_rob_busy[t]) n[t] = 2;
      else if (dec_squash[t] && m_st[t] != 2) begin n[t] = 2; rd[t] = 1; rpc[t] = dec_target[t*PC_W +: PC_W]; end
      else if (stl[t] && m_st[t] != 4 && m_st[t] != 5) n[t] = 3;
      else if (m_st[t] == 3 || m_st[t] == 2) n[t] = 0;
      else q[t] = 1;
    end
    if (miss_valid && !m_cblk && m_st[miss_tid] == 0 && q[miss_tid]) iss = int'(miss_tid);
    for (int t = 0; t < NT; t++) begin
      if (!q[t]) continue;
      case (m_st[t])
        4: if (resp_valid && int'(resp_tid) == t && resp_tag == m_tag[t]) begin
             n[t] = stl[t] ? 3 : 6; took = 1;
           end
        6: n[t] = 0;
        0: if (iss == t) n[t] = miss_accept ? 4 : 5;
           else if (fault_evt[t]) n[t] = 7;
           else if (quiesce_evt[t]) n[t] = 8;
        5: if (m_cblk && m_own == t && retry_pulse && retry_accept) n[t] = 4;
        default: ;
      endcase
    end
    if (resp_valid && !took) m_drop = m_drop + CNT_W'(1);
    if (iss >= 0 && !miss_accept) begin ncblk = 1; m_own = iss; end
    else if (m_cblk && (!q[m_own] || (retry_pulse && retry_accept))) ncblk = 0;
    if (iss >= 0) begin m_tag[iss] = m_seq[iss]; m_seq[iss] = m_seq[iss] + 1'b1; end
    nact = 0;
    for (int t = 0; t < NT; t++) if (thread_active[t] && busy_code(n[t])) nact = 1;
    m_on = nact && !m_act; m_off = !nact && m_act; m_act = nact;
    m_cblk = ncblk;
    for (int t = 0; t < NT; t++) begin
      m_st[t] = n[t];
      if (rd[t]) begin m_pc[t] = rpc[t]; m_npc[t] = rpc[t] + PC_W'(INST_BYTES); end
    end
  endtask

  task automatic chk(string what, int t, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s thread %0d: actual %0h expected %0h", lbl, what, t, act, exp);
    end
  endtask

  task automatic compare();
    for (int t = 0; t < NT; t++) begin
      chk("state", t, 64'(thread_state[t*4 +: 4]), 64'(m_st[t]));
      chk("pc", t, 64'(fetch_pc[t*PC_W +: PC_W]), 64'(m_pc[t]));
      chk("npc", t, 64'(fetch_npc[t*PC_W +: PC_W]), 64'(m_npc[t]));
      chk("tag", t, 64'(miss_tag[t*TAG_W +: TAG_W]), 64'(m_tag[t]));
    end
    chk("cache_blocked", 0, 64'(cache_blocked), 64'(m_cblk));
    chk("dropped", 0, 64'(dropped_resp), 64'(m_drop));
    chk("active", 0, 64'(stage_active), 64'(m_act));
    chk("woke", 0, 64'(stage_woke), 64'(m_on));
    chk("slept", 0, 64'(stage_slept), 64'(m_off));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    clear_in();
    thread_active = '0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    lbl = "R1"; compare();

    lbl = "R9"; thread_active = 2'b11; cyc();
    thread_active = 2'b00; cyc();
    thread_active = 2'b11; cyc();

    lbl = "R5"; miss_valid = 1; miss_tid = 0; miss_accept = 1; cyc();
    miss_tid = 1; miss_accept = 0; cyc();
    miss_tid = 0; miss_accept = 1; cyc();   // port blocked: ignored
    clear_in();

    lbl = "R7"; retry_pulse = 1; retry_accept = 0; cyc();
    retry_accept = 1; cyc();
    clear_in();

    lbl = "R6"; resp_valid = 1; resp_tid = 0; resp_tag = 3'd5; cyc();
    resp_tag = 3'd0; stg_block[1*NSTG+0] = 1; cyc();   // t1 in WaitResp keeps waiting
    clear_in(); cyc();
    resp_valid = 1; resp_tid = 1; resp_tag = 3'd0; cyc();   // stalled: goes Blocked
    clear_in(); stg_unblock[1*NSTG+0] = 1; cyc();
    clear_in();

    lbl = "R2"; stg_block[0*NSTG+2] = 1; cyc();
    clear_in(); cyc();
    stg_unblock[0*NSTG+2] = 1; cyc();
    clear_in(); ctx_stall = 1; cyc();
    clear_in(); cyc();

    lbl = "R3"; cmt_squash[0] = 1; cmt_target[0 +: PC_W] = 32'h1000;
    dec_squash[0] = 1; dec_target[0 +: PC_W] = 32'h2000; stg_block[0*NSTG+1] = 1; cyc();
    clear_in(); stg_unblock[0*NSTG+1] = 1; cyc();
    clear_in(); cyc();

    lbl = "R4"; cmt_rob_busy[1] = 1; cyc();
    dec_squash[1] = 1; dec_target[PC_W +: PC_W] = 32'h3000; cyc();
    cmt_rob_busy[1] = 0; cyc();
    clear_in(); cyc();

    lbl = "R8"; fault_evt[1] = 1; quiesce_evt[0] = 1; cyc();
    clear_in(); cyc();
    cmt_squash[1] = 1; cmt_target[PC_W +: PC_W] = 32'h40; cyc();
    clear_in(); cyc();

    lbl = "RND";
    for (int i = 0; i < 4000; i++) begin
      logic [NT*NSTG-1:0] b;
      for (int k = 0; k < NT*NSTG; k++) begin
        b[k] = ($urandom % 16) == 0;
        stg_unblock[k] = !b[k] && (($urandom % 6) == 0);
      end
      stg_block = b;
      ctx_stall = ($urandom % 40) == 0;
      for (int t = 0; t < NT; t++) begin
        thread_active[t] = ($urandom % 8) != 0;
        cmt_squash[t] = ($urandom % 30) == 0;
        cmt_rob_busy[t] = ($urandom % 25) == 0;
        dec_squash[t] = ($urandom % 20) == 0;
        cmt_target[t*PC_W +: PC_W] = $urandom & 32'hFFFF_FFFC;
        dec_target[t*PC_W +: PC_W] = $urandom & 32'hFFFF_FFFC;
        fault_evt[t] = ($urandom % 40) == 0;
        quiesce_evt[t] = ($urandom % 50) == 0;
      end
      miss_valid = ($urandom % 3) == 0;
      miss_tid = TID_W'($urandom % NT);
      miss_accept = ($urandom % 4) != 0;
      retry_pulse = ($urandom % 4) == 0;
      retry_accept = ($urandom % 2) == 0;
      resp_valid = ($urandom % 3) == 0;
      resp_tid = TID_W'($urandom % NT);
      resp_tag = (($urandom % 5) == 0) ? TAG_W'($urandom) : m_tag[resp_tid];
      cyc();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule